// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block gathers interrupt requests from eight timer channels into one byte of flags and drives a single active-low interrupt request line to the processor. Each flag bit belongs to one channel. A flag stays set until software clears it. Software has two register addresses on a byte-wide register port. A write to the clear address drops the flags selected by a mask. A write to the set address raises the flags selected by a mask, which lets software force an interrupt. A read of either address returns the current flag byte.

Seven of the channels are edge driven. A one-cycle expiry pulse from a timer sets that channel's flag, but only when the timer's interrupt-enable bit is 1. The serial channel (channel 4) is different. It takes no notice of its timer's expiry. Its flag is driven at level by two conditions: receive data available and transmit buffer empty. Each condition has its own enable. Because of this, the flag reappears on every clock for as long as an enabled condition is true.

The register port has no back-pressure. A write is taken in the cycle its strobe is high, so the port carries no valid/ready pair. Read data is the flag byte at all times and costs no wait cycle. All other pins are plain control and status levels.

Top module: `tih_irq_hub`

## Requirements
- R1: After reset all eight flags are 0 and `irq_n` is 1.
- R2: Bit n of `reg_rdata` is the flag of channel n. The value read does not depend on `reg_sel`.
- R3: A write with `reg_sel` = 0 (the clear address) zeroes, after the next clock edge, every flag whose data bit is 1. The other flags keep their value.
- R4: A write with `reg_sel` = 1 (the set address) raises, after the next clock edge, every flag whose data bit is 1. The other flags keep their value, so a data byte of 0 changes nothing.
- R5: For every channel except 4, an expiry pulse on `tmr_expire[n]` sets flag n after the next clock edge when `tmr_int_en[n]` is 1. When `tmr_int_en[n]` is 0 the pulse has no effect.
- R6: Flag 4 takes no notice of `tmr_expire[4]` and `tmr_int_en[4]`. It is set when (`ser_rx_ready` and `ser_rx_int_en`) or (`ser_tx_empty` and `ser_tx_int_en`) is true. A condition whose enable is 0 has no effect.
- R7: A clear of bit 4 while an enabled serial condition is still true leaves flag 4 at 1. Once the condition is gone, a clear of bit 4 drops the flag and it stays 0.
- R8: `irq_n` is 0 exactly when at least one flag is 1.
- R9: When an enabled expiry and a clear of the same bit fall in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register address: 0 = clear by mask, 1 = set by mask |
| reg_wdata | input | 8 | Write data, used as the mask |
| reg_rdata | output | 8 | Current flag byte, bit n = channel n |
| tmr_expire | input | 8 | One-cycle expiry pulses, one per timer |
| tmr_int_en | input | 8 | Interrupt-enable bit of each timer (bit 7 of its control register A) |
| ser_rx_ready | input | 1 | Serial receive data available |
| ser_tx_empty | input | 1 | Serial transmit buffer empty |
| ser_rx_int_en | input | 1 | Enable for the receive interrupt |
| ser_tx_int_en | input | 1 | Enable for the transmit interrupt |
| irq_n | output | 1 | Interrupt request to the processor, active low |

## Verification
Two functions can fall in the same cycle: a hardware request for a bit (a timer expiry, or the serial level) and a software clear of that same bit. The bench provokes this in two ways. It writes a clear mask in the same cycle as an enabled expiry on a channel whose flag was 0 beforehand. It also clears bit 4 while an enabled serial condition is held. In both cases the flag must read 1 one edge later, and the bits of the mask that had no request must read 0. The bench then removes the serial condition and clears bit 4 again, to show that the clear itself works.

// File: rtl/tih_pkg.sv
package tih_pkg;

  // Register address decode: the offset selects the operation
  typedef enum logic {
    ADDR_CLR = 1'b0,
    ADDR_SET = 1'b1
  } tih_addr_e;

  localparam int unsigned TIH_N_CH   = 8;
  localparam int unsigned TIH_SER_CH = 4;

endpackage

// File: rtl/tih_wr_decode.sv
module tih_wr_decode
  import tih_pkg::*;
#(
  parameter int unsigned N_CH = TIH_N_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            sel_i,
  input  logic [N_CH-1:0] data_i,
  output logic [N_CH-1:0] set_mask_o,
  output logic [N_CH-1:0] clr_mask_o
);

  tih_addr_e addr;

  always_comb begin
    addr       = tih_addr_e'(sel_i);
    set_mask_o = '0;
    clr_mask_o = '0;
    if (wr_i) begin
      unique case (addr)
        ADDR_SET: set_mask_o = data_i;
        ADDR_CLR: clr_mask_o = data_i;
        default:  ;
      endcase
    end
  end

  // A write to one address must never reach the other address's mask
  AST_SET_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == 1'b0) |-> (set_mask_o == '0)); // R3
  AST_CLR_ONLY_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == 1'b1) |-> (clr_mask_o == '0)); // R4

endmodule

// File: rtl/tih_ser_level.sv
module tih_ser_level (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_ready_i,
  input  logic tx_empty_i,
  input  logic rx_en_i,
  input  logic tx_en_i,
  output logic req_o
);

  logic rx_req;
  logic tx_req;

  always_comb begin
    rx_req = rx_ready_i & rx_en_i;
    tx_req = tx_empty_i & tx_en_i;
    req_o  = rx_req | tx_req;
  end

  // With both enables low, the serial conditions cannot raise a request
  AST_SER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_i && !tx_en_i) |-> !req_o); // R6

endmodule

// File: rtl/tih_flag_cell.sv
module tih_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  // Hardware request and software set win over a clear, so no event is lost
  always_comb begin
    flag_d = flag_q;
    if (sw_clr_i) flag_d = 1'b0;
    if (hw_set_i || sw_set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set_i && sw_clr_i) |=> flag_o); // R9
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_i |=> flag_o); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !hw_set_i && !sw_set_i) |=> !flag_o); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_clr_i && !hw_set_i && !sw_set_i) |=> $stable(flag_o)); // R3

endmodule

// File: rtl/tih_irq_hub.sv
module tih_irq_hub
  import tih_pkg::*;
#(
  parameter int unsigned N_CH   = TIH_N_CH,
  parameter int unsigned SER_CH = TIH_SER_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [N_CH-1:0] reg_wdata,
  output logic [N_CH-1:0] reg_rdata,
  input  logic [N_CH-1:0] tmr_expire,
  input  logic [N_CH-1:0] tmr_int_en,
  input  logic            ser_rx_ready,
  input  logic            ser_tx_empty,
  input  logic            ser_rx_int_en,
  input  logic            ser_tx_int_en,
  output logic            irq_n
);

  logic [N_CH-1:0] set_mask;
  logic [N_CH-1:0] clr_mask;
  logic [N_CH-1:0] hw_req;
  logic [N_CH-1:0] flags;
  logic            ser_req;

  tih_wr_decode #(.N_CH(N_CH)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .sel_i      (reg_sel),
    .data_i     (reg_wdata),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask)
  );

  tih_ser_level u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_ready_i (ser_rx_ready),
    .tx_empty_i (ser_tx_empty),
    .rx_en_i    (ser_rx_int_en),
    .tx_en_i    (ser_tx_int_en),
    .req_o      (ser_req)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    if (ch == SER_CH) begin : g_serial
      // Level source: the timer behind this channel only sets the baud rate
      assign hw_req[ch] = ser_req;
    end else begin : g_timer
      assign hw_req[ch] = tmr_expire[ch] & tmr_int_en[ch];
    end

    tih_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set_i (hw_req[ch]),
      .sw_set_i (set_mask[ch]),
      .sw_clr_i (clr_mask[ch]),
      .flag_o   (flags[ch])
    );
  end

  assign reg_rdata = flags;
  assign irq_n     = ~|flags;

  // Port-level checks
  AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata != '0) |=> !irq_n); // R8
  AST_TIMER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_expire & tmr_int_en & ~(N_CH'(1) << SER_CH)) != '0)
      |=> ((reg_rdata & $past(tmr_expire & tmr_int_en & ~(N_CH'(1) << SER_CH))) != '0)); // R5
  AST_SER_IGNORES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire[SER_CH] && tmr_int_en[SER_CH] && !ser_req && !reg_rdata[SER_CH]
      && !(reg_wr && reg_sel && reg_wdata[SER_CH])) |=> !reg_rdata[SER_CH]); // R6
  AST_SER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((ser_rx_ready && ser_rx_int_en) || (ser_tx_empty && ser_tx_int_en))
      |=> reg_rdata[SER_CH]); // R7

endmodule

// File: tb/sim_tih_irq_hub.sv
module sim_tih_irq_hub;

  localparam int NV = 14;
  localparam int VW = 38;

  // {sel, wr, wdata, expire, int_en, rx, tx, rxen, txen, expected flags}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h81, 8'h00, 8'h00, 4'b0000, 8'h81}, // R4 set by mask
    {1'b0, 1'b1, 8'h01, 8'h00, 8'h00, 4'b0000, 8'h80}, // R3 clear by mask
    {1'b0, 1'b0, 8'h00, 8'h06, 8'h02, 4'b0000, 8'h82}, // R5 bit2 not enabled
    {1'b0, 1'b0, 8'h00, 8'h10, 8'hFF, 4'b0000, 8'h82}, // R6 expiry on 4 ignored
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b1010, 8'h92}, // R6 receive ready
    {1'b0, 1'b1, 8'h10, 8'h00, 8'h00, 4'b1010, 8'h92}, // R7 clear while level held
    {1'b0, 1'b1, 8'h10, 8'h00, 8'h00, 4'b0010, 8'h82}, // R7 clear after level gone
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0110, 8'h82}, // R6 tx enable low
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 4'b0111, 8'h92}, // R6 transmit empty
    {1'b0, 1'b1, 8'h12, 8'h00, 8'h00, 4'b0011, 8'h80}, // R3 two bits cleared
    {1'b0, 1'b1, 8'h02, 8'h02, 8'h02, 4'b0000, 8'h82}, // R9 expiry beats clear
    {1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h82}, // R4 zero data no change
    {1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 4'b0000, 8'h00}, // R8 all cleared
    {1'b0, 1'b0, 8'h00, 8'hEF, 8'hEF, 4'b0000, 8'hEF}  // R5 all timer channels
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] tmr_expire = '0;
  logic [7:0] tmr_int_en = '0;
  logic       ser_rx_ready = 1'b0;
  logic       ser_tx_empty = 1'b0;
  logic       ser_rx_int_en = 1'b0;
  logic       ser_tx_int_en = 1'b0;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  tih_irq_hub u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .tmr_expire    (tmr_expire),
    .tmr_int_en    (tmr_int_en),
    .ser_rx_ready  (ser_rx_ready),
    .ser_tx_empty  (ser_tx_empty),
    .ser_rx_int_en (ser_rx_int_en),
    .ser_tx_int_en (ser_tx_int_en),
    .irq_n         (irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    tmr_expire = '0; tmr_int_en = '0;
    ser_rx_ready = 1'b0; ser_tx_empty = 1'b0;
    ser_rx_int_en = 1'b0; ser_tx_int_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", reg_rdata, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      reg_sel       = v[37];
      reg_wr        = v[36];
      reg_wdata     = v[35:28];
      tmr_expire    = v[27:20];
      tmr_int_en    = v[19:12];
      ser_rx_ready  = v[11];
      ser_tx_empty  = v[10];
      ser_rx_int_en = v[9];
      ser_tx_int_en = v[8];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("table %0d flags", i), reg_rdata, v[7:0]);
      chk($sformatf("R8 table %0d irq_n", i), {7'd0, irq_n}, {7'd0, (v[7:0] == 8'h00)});
    end

    // R2: same byte on either address, bit order by channel
    idle();
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h5A;
    @(posedge clk); @(negedge clk);
    idle();
    reg_sel = 1'b0;
    @(negedge clk);
    chk("R2 read at clear address", reg_rdata, 8'hFF);
    reg_sel = 1'b1;
    @(negedge clk);
    chk("R2 read at set address", reg_rdata, 8'hFF);

    // R2 bit mapping: clear all, then one expiry on channel 6
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hFF;
    @(posedge clk); @(negedge clk);
    idle();
    tmr_expire = 8'h40; tmr_int_en = 8'h40;
    @(posedge clk); @(negedge clk);
    idle();
    chk("R2 channel 6 bit position", reg_rdata, 8'h40);
    chk("R8 single flag irq_n", {7'd0, irq_n}, 8'h00);

    // R9 on the serial channel: clear bit 4 together with transmit level
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h50;
    ser_tx_empty = 1'b1; ser_tx_int_en = 1'b1;
    @(posedge clk); @(negedge clk);
    idle();
    chk("R9 serial level beats clear", reg_rdata, 8'h10);

    // R1: reset in mid-run drops all flags
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'hFF;
    @(posedge clk); @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", reg_rdata, 8'h00);
    chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule